// File: doc/BRIEF.md
# Board Glue Control Register Set

This block is a small set of bus-accessible registers that steer board-level routing and indicator signals. Software writes it through a simple synchronous register bus. Each write acts directly on pins:

- It lights or clears two user LEDs.
- It selects which memory-map window the surrounding address decoder uses.
- It releases or re-asserts an open-collector configuration line.
- It connects or disconnects an external non-maskable interrupt from the processor.
- It turns two bidirectional timer-clock pins around between input and output.

There are three registers, each one bus word wide, selected by a word index on `bus_addr`:

- Index 0 is the indicator register.
- Index 1 is the configuration register.
- Index 2 is the timer direction register.
- Index 3 is unmapped.

A status LED output shows the inverse of the configuration-done input, so it is lit while the logic is not yet configured. The level of the configuration line can never be read back; its bit position always reads 0.

Writes are captured on the rising edge at which `bus_wr` is high. Reads are registered: `bus_rdata` is loaded at the edge where `bus_rd` is high and holds between reads.

Top module: `glue_ctl_regs`

## Requirements
- R1: Reset (synchronous, active high) sets the following state:
  - both user LEDs off, the map select at 1, the configuration line driven low and NMI disconnected;
  - both timer pins as inputs, the status LED lit and `bus_rdata` at 0.
- R2: In the indicator register (index 0), bit 0 drives `led_user_o[0]` and bit 1 drives `led_user_o[1]`. A 1 lights the LED. The new value appears on the cycle after the write edge.
- R3: Indicator register bit 2 drives `map_large_o`: 1 selects the large-memory window and 0 the small one. The bit is writable.
- R4: `led_status_o` equals the inverse of `cfg_done_i` as sampled at the previous rising edge.
- R5: Configuration register (index 1) bit 6 controls the line. Writing 0 sets `config_drv_low_o` to 1, which drives the line low. Writing 1 clears it, which tri-states the line.
- R6: A read of the configuration register always returns 0 in bit 6, whatever was written there. Bit 7 reads back as written.
- R7: While configuration bit 7 is 1, `nmi_cpu_o` equals `nmi_ext_i` from the previous edge. While bit 7 is 0, `nmi_cpu_o` stays 0.
- R8: Timer register (index 2) bit 4 sets `tclk_pin_oe[0]` and bit 5 sets `tclk_pin_oe[1]`. While a pin's enable is 1, `tclk_pin_o` for that pin carries `cpu_tout_i` for the same channel. While the enable is 0, `tclk_pin_o` is 0.
- R9: `cpu_tinp_o[i]` always equals `tclk_pin_i[i]`, whatever the pin direction.
- R10: Reserved bits read as 0, and writes to them have no effect. Index 3 reads as 0, and a write to it changes no output.
- R11: A read returns the register value held before the edge at which `bus_rd` is high, including when a write to the same register occurs at that edge. `bus_rdata` holds its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Register word index |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| cfg_done_i | input | 1 | Configuration-done input |
| led_status_o | output | 1 | Status LED, lit while not configured |
| led_user_o | output | N_ULED | User LEDs, 1 = lit |
| map_large_o | output | 1 | Memory-map window select |
| config_drv_low_o | output | 1 | Open-drain enable for the configuration line |
| nmi_ext_i | input | 1 | External NMI from the connector |
| nmi_cpu_o | output | 1 | Gated NMI to the processor |
| tclk_pin_i | input | N_TCLK | Timer pin input levels |
| tclk_pin_o | output | N_TCLK | Timer pin output levels |
| tclk_pin_oe | output | N_TCLK | Timer pin output enables |
| cpu_tout_i | input | N_TCLK | Processor timer outputs |
| cpu_tinp_o | output | N_TCLK | Processor timer inputs |

## Verification
The hardest case to reach from the ports is a read and a write to the same register at the same edge. The read must return the old contents while the outputs take the new ones, and for the configuration register the masked bit must stay 0 in either case. The random stimulus therefore raises `bus_rd` and `bus_wr` together often, with random addresses that include the unmapped index. Directed steps also write all ones to every index, so every reserved bit and the masked bit see a 1.

// File: rtl/glue_pkg.sv
package glue_pkg;
  localparam int DATA_W      = 32;
  localparam int ADDR_W      = 2;
  localparam int N_ULED      = 2;
  localparam int N_TCLK      = 2;
  localparam int LED_MAP_BIT = 2;
  localparam int CFG_REL_BIT = 6;
  localparam int CFG_NMI_BIT = 7;
  localparam int TMR_DIR_LSB = 4;
  localparam int IDX_LED     = 0;
  localparam int IDX_CFG     = 1;
  localparam int IDX_TMR     = 2;
endpackage

// File: rtl/glue_regfile.sv
module glue_regfile
  import glue_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int AW  = ADDR_W,
  parameter int NL  = N_ULED,
  parameter int NT  = N_TCLK
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [NL-1:0] uled_q,
  output logic          map_q,
  output logic          rel_q,
  output logic          nmi_en_q,
  output logic [NT-1:0] tdir_q
);
  localparam int TMR_MSB = TMR_DIR_LSB + NT - 1;

  logic sel_led, sel_cfg, sel_tmr;
  logic [DW-1:0] rd_val;

  assign sel_led = (addr == AW'(IDX_LED));
  assign sel_cfg = (addr == AW'(IDX_CFG));
  assign sel_tmr = (addr == AW'(IDX_TMR));

  always_ff @(posedge clk) begin
    if (rst) begin
      uled_q   <= '0;
      map_q    <= 1'b1;
      rel_q    <= 1'b0;
      nmi_en_q <= 1'b0;
      tdir_q   <= '0;
    end else if (wr) begin
      if (sel_led) begin
        uled_q <= wdata[NL-1:0];
        map_q  <= wdata[LED_MAP_BIT];
      end
      if (sel_cfg) begin
        rel_q    <= wdata[CFG_REL_BIT];
        nmi_en_q <= wdata[CFG_NMI_BIT];
      end
      if (sel_tmr) begin
        tdir_q <= wdata[TMR_MSB:TMR_DIR_LSB];
      end
    end
  end

  // Read mux: the release bit of the config register is never exposed.
  always_comb begin
    rd_val = '0;
    if (sel_led) begin
      rd_val[NL-1:0]      = uled_q;
      rd_val[LED_MAP_BIT] = map_q;
    end else if (sel_cfg) begin
      rd_val[CFG_NMI_BIT] = nmi_en_q;
    end else if (sel_tmr) begin
      rd_val[TMR_MSB:TMR_DIR_LSB] = tdir_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      rdata <= rd_val;
    end
  end
endmodule

// File: rtl/glue_sig_out.sv
module glue_sig_out (
  input  logic clk,
  input  logic rst,
  input  logic cfg_done_i,
  input  logic nmi_ext_i,
  input  logic nmi_en,
  input  logic rel,
  output logic led_status_o,
  output logic nmi_cpu_o,
  output logic config_drv_low_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      led_status_o <= 1'b1;
      nmi_cpu_o    <= 1'b0;
    end else begin
      led_status_o <= ~cfg_done_i;
      nmi_cpu_o    <= nmi_ext_i & nmi_en;
    end
  end

  // Open-drain enable: pull low unless software has released the line.
  assign config_drv_low_o = ~rel;
endmodule

// File: rtl/glue_tclk_route.sv
module glue_tclk_route #(
  parameter int NT = 2
) (
  input  logic [NT-1:0] dir,
  input  logic [NT-1:0] pin_i,
  input  logic [NT-1:0] tout_i,
  output logic [NT-1:0] pin_o,
  output logic [NT-1:0] pin_oe,
  output logic [NT-1:0] tinp_o
);
  for (genvar g = 0; g < NT; g++) begin : g_ch
    assign pin_oe[g] = dir[g];
    assign pin_o[g]  = dir[g] & tout_i[g];
    assign tinp_o[g] = pin_i[g];
  end
endmodule

// File: rtl/glue_ctl_regs.sv
module glue_ctl_regs
  import glue_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int NL = N_ULED,
  parameter int NT = N_TCLK
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          cfg_done_i,
  output logic          led_status_o,
  output logic [NL-1:0] led_user_o,
  output logic          map_large_o,
  output logic          config_drv_low_o,
  input  logic          nmi_ext_i,
  output logic          nmi_cpu_o,
  input  logic [NT-1:0] tclk_pin_i,
  output logic [NT-1:0] tclk_pin_o,
  output logic [NT-1:0] tclk_pin_oe,
  input  logic [NT-1:0] cpu_tout_i,
  output logic [NT-1:0] cpu_tinp_o
);
  logic          rel_q, nmi_en_q;
  logic [NT-1:0] tdir_q;

  glue_regfile #(.DW(DW), .AW(AW), .NL(NL), .NT(NT)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr       (bus_wr),
    .rd       (bus_rd),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .rdata    (bus_rdata),
    .uled_q   (led_user_o),
    .map_q    (map_large_o),
    .rel_q    (rel_q),
    .nmi_en_q (nmi_en_q),
    .tdir_q   (tdir_q)
  );

  glue_sig_out u_sig (
    .clk              (clk),
    .rst              (rst),
    .cfg_done_i       (cfg_done_i),
    .nmi_ext_i        (nmi_ext_i),
    .nmi_en           (nmi_en_q),
    .rel              (rel_q),
    .led_status_o     (led_status_o),
    .nmi_cpu_o        (nmi_cpu_o),
    .config_drv_low_o (config_drv_low_o)
  );

  glue_tclk_route #(.NT(NT)) u_tclk (
    .dir    (tdir_q),
    .pin_i  (tclk_pin_i),
    .tout_i (cpu_tout_i),
    .pin_o  (tclk_pin_o),
    .pin_oe (tclk_pin_oe),
    .tinp_o (cpu_tinp_o)
  );
endmodule

// File: rtl/glue_ctl_regs_chk.sv
module glue_ctl_regs_chk
  import glue_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int NL = N_ULED,
  parameter int NT = N_TCLK
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          cfg_done_i,
  input logic          led_status_o,
  input logic          map_large_o,
  input logic          config_drv_low_o,
  input logic          nmi_ext_i,
  input logic          nmi_cpu_o,
  input logic [NT-1:0] tclk_pin_oe
);
  localparam int TMR_MSB = TMR_DIR_LSB + NT - 1;

  assert_map_write_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(IDX_LED)) |=> map_large_o == $past(bus_wdata[LED_MAP_BIT]));

  assert_status_led_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> led_status_o == !$past(cfg_done_i));

  assert_config_release_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(IDX_CFG)) |=> config_drv_low_o == !$past(bus_wdata[CFG_REL_BIT]));

  assert_cfg_masked_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == AW'(IDX_CFG)) |=> !bus_rdata[CFG_REL_BIT]);

  assert_nmi_gate_R7: assert property (@(posedge clk) disable iff (rst)
    nmi_cpu_o |-> $past(nmi_ext_i));

  assert_tdir_write_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(IDX_TMR)) |=> tclk_pin_oe == $past(bus_wdata[TMR_MSB:TMR_DIR_LSB]));

  assert_tdir_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == AW'(IDX_TMR)) |=> $stable(tclk_pin_oe));

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind glue_ctl_regs glue_ctl_regs_chk #(.DW(DW), .AW(AW), .NL(NL), .NT(NT)) u_chk (
  .clk              (clk),
  .rst              (rst),
  .bus_wr           (bus_wr),
  .bus_rd           (bus_rd),
  .bus_addr         (bus_addr),
  .bus_wdata        (bus_wdata),
  .bus_rdata        (bus_rdata),
  .cfg_done_i       (cfg_done_i),
  .led_status_o     (led_status_o),
  .map_large_o      (map_large_o),
  .config_drv_low_o (config_drv_low_o),
  .nmi_ext_i        (nmi_ext_i),
  .nmi_cpu_o        (nmi_cpu_o),
  .tclk_pin_oe      (tclk_pin_oe)
);

// File: tb/glue_ctl_regs_tb.sv
module glue_ctl_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cfg_done_i = 1'b0, nmi_ext_i = 1'b0;
  logic        led_status_o, map_large_o, config_drv_low_o, nmi_cpu_o;
  logic [1:0]  led_user_o, tclk_pin_i = '0, tclk_pin_o, tclk_pin_oe, cpu_tout_i = '0, cpu_tinp_o;

  int errors = 0;
  int checks = 0;

  // Reference model state
  logic [1:0]  m_led;
  logic        m_map, m_rel, m_nmi_en, m_status, m_nmi;
  logic [1:0]  m_tdir;
  logic [31:0] m_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  glue_ctl_regs u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_done_i(cfg_done_i),
    .led_status_o(led_status_o), .led_user_o(led_user_o), .map_large_o(map_large_o),
    .config_drv_low_o(config_drv_low_o), .nmi_ext_i(nmi_ext_i), .nmi_cpu_o(nmi_cpu_o),
    .tclk_pin_i(tclk_pin_i), .tclk_pin_o(tclk_pin_o), .tclk_pin_oe(tclk_pin_oe),
    .cpu_tout_i(cpu_tout_i), .cpu_tinp_o(cpu_tinp_o)
  );

  function automatic logic [31:0] exp_read(input logic [1:0] a);
    logic [31:0] v = '0;
    case (a)
      2'd0: begin v[1:0] = m_led; v[2] = m_map; end
      2'd1: v[7] = m_nmi_en;            // bit 6 masked
      2'd2: v[5:4] = m_tdir;
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R2 led_user", 32'(led_user_o), 32'(m_led));
    chk("R3 map_large", 32'(map_large_o), 32'(m_map));
    chk("R4 led_status", 32'(led_status_o), 32'(m_status));
    chk("R5 config_drv_low", 32'(config_drv_low_o), 32'(!m_rel));
    chk("R7 nmi_cpu", 32'(nmi_cpu_o), 32'(m_nmi));
    chk("R8 tclk_pin_oe", 32'(tclk_pin_oe), 32'(m_tdir));
    chk("R8 tclk_pin_o", 32'(tclk_pin_o), 32'(m_tdir & cpu_tout_i));
    chk("R9 cpu_tinp", 32'(cpu_tinp_o), 32'(tclk_pin_i));
    chk("R11 rdata", bus_rdata, m_rdata);
  endtask

  // Drive at negedge, model the edge, check at the following negedge.
  task automatic step(input logic wr, input logic rd, input logic [1:0] a, input logic [31:0] d,
                      input logic done, input logic nmi);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    cfg_done_i = done; nmi_ext_i = nmi;
    tclk_pin_i = 2'($urandom); cpu_tout_i = 2'($urandom);
    @(posedge clk);
    m_status = ~done;
    m_nmi    = nmi & m_nmi_en;
    if (rd) m_rdata = exp_read(a);
    if (wr) begin
      case (a)
        2'd0: begin m_led = d[1:0]; m_map = d[2]; end
        2'd1: begin m_rel = d[6]; m_nmi_en = d[7]; end
        2'd2: m_tdir = d[5:4];
        default: ;
      endcase
    end
    @(negedge clk);
    check_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values
    chk("R1 led_user", 32'(led_user_o), 32'd0);
    chk("R1 map_large", 32'(map_large_o), 32'd1);
    chk("R1 config_drv_low", 32'(config_drv_low_o), 32'd1);
    chk("R1 nmi_cpu", 32'(nmi_cpu_o), 32'd0);
    chk("R1 tclk_pin_oe", 32'(tclk_pin_oe), 32'd0);
    chk("R1 led_status", 32'(led_status_o), 32'd1);
    chk("R1 rdata", bus_rdata, 32'd0);
    m_led = '0; m_map = 1'b1; m_rel = 1'b0; m_nmi_en = 1'b0; m_tdir = '0;
    m_rdata = '0; m_status = 1'b1; m_nmi = 1'b0;
    rst = 1'b0;

    // R10: all-ones to each index, then read each back
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 2'(i), 32'hFFFF_FFFF, 1'b1, 1'b1);
    step(1'b0, 1'b1, 2'd0, 32'h0, 1'b1, 1'b1);
    chk("R10 led reserved", bus_rdata, 32'h0000_0007);
    step(1'b0, 1'b1, 2'd1, 32'h0, 1'b1, 1'b1);
    chk("R6 cfg masked", bus_rdata, 32'h0000_0080);
    step(1'b0, 1'b1, 2'd2, 32'h0, 1'b1, 1'b0);
    chk("R10 tmr reserved", bus_rdata, 32'h0000_0030);
    step(1'b0, 1'b1, 2'd3, 32'h0, 1'b0, 1'b0);
    chk("R10 unmapped read", bus_rdata, 32'h0);
    // R3: clear map bit, R5: re-assert line
    step(1'b1, 1'b0, 2'd0, 32'h0000_0001, 1'b0, 1'b0);
    chk("R3 map cleared", 32'(map_large_o), 32'd0);
    step(1'b1, 1'b0, 2'd1, 32'h0000_0000, 1'b0, 1'b1);
    chk("R5 line driven", 32'(config_drv_low_o), 32'd1);
    // R11: read and write same register at the same edge returns old value
    step(1'b1, 1'b1, 2'd2, 32'h0000_0010, 1'b0, 1'b0);
    chk("R11 read-before-write", bus_rdata, 32'h0000_0030);

    for (int n = 0; n < 400; n++) begin
      step(1'($urandom), 1'($urandom), 2'($urandom), $urandom, 1'($urandom), 1'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule